// File: doc/BRIEF.md
# Odd-Word Access Splitter Sequencer

This block sits on the host side of a 16-bit I/O bus whose two data lanes are enabled one by one: the low lane (bits 7..0) holds the byte at an even address and the high lane (bits 15..8) holds the byte at an odd address. The host gives it word or byte requests at any byte address through a valid/ready port. The block turns each request into bus cycles and hands back one response pulse when the last cycle has completed.

A word whose first byte is at an even address goes out as one bus cycle with both lanes enabled. A word that starts at an odd address N cannot go out that way. It becomes two byte cycles. The first cycle targets N on the high lane and the second targets N+1 on the low lane. The block moves the bytes across lanes for a split write and rebuilds the word for a split read. A byte request gives one cycle on the lane that address bit 0 selects. The bus ends each cycle with a completion input, so any number of wait states is allowed.

Top module: `oddword_bus_seq`

## Requirements
- R1: After reset, and while reset is held, req_ready is 1 and bus_req, bus_hi_en, bus_lo_en and rsp_valid are all 0.
- R2: A word request (req_byte=0) at an even address N gives exactly one bus cycle at address N with bus_hi_en=1 and bus_lo_en=1. bus_wdata carries req_wdata unchanged. A read returns bus_rdata unchanged.
- R3: A word request at an odd address N gives exactly two bus cycles. The first is at address N with only bus_hi_en=1. The second is at address N+1 with only bus_lo_en=1. No cycle at an odd address ever enables the low lane.
- R4: On a split write, the first cycle drives req_wdata[7:0] on bus_wdata[15:8]. The second cycle drives req_wdata[15:8] on bus_wdata[7:0].
- R5: On a split read, rsp_rdata[7:0] is bus_rdata[15:8] from the first cycle and rsp_rdata[15:8] is bus_rdata[7:0] from the second cycle.
- R6: A byte request (req_byte=1) gives exactly one cycle at address N. When N[0]=0 it enables only the low lane and drives req_wdata[7:0] on bus_wdata[7:0]. When N[0]=1 it enables only the high lane and drives req_wdata[7:0] on bus_wdata[15:8]. A byte read returns the enabled lane's byte in rsp_rdata[7:0] with rsp_rdata[15:8]=0.
- R7: req_ready falls in the cycle after a request is accepted (req_valid and req_ready both 1 at a clock edge). It stays 0 until the cycle after rsp_valid.
- R8: rsp_valid is a one-cycle pulse in the cycle after the bus_done of the last bus cycle. For a write, rsp_rdata is 0 during that pulse.
- R9: While bus_req is 1 and bus_done is 0, bus_addr, the lane enables and bus_wdata hold their values, and the sequence advances only on bus_done.
- R10: bus_we equals the accepted request's req_write during every bus cycle of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = single byte, 0 = word |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_wdata | input | 2*BYTE_W | Write data, low byte at req_addr |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 2*BYTE_W | Assembled read data (0 for writes) |
| bus_req | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle direction, 1 = write |
| bus_addr | output | ADDR_W | Byte address of the bus cycle |
| bus_hi_en | output | 1 | High lane (odd byte) enabled |
| bus_lo_en | output | 1 | Low lane (even byte) enabled |
| bus_wdata | output | 2*BYTE_W | Lane-steered write data |
| bus_rdata | input | 2*BYTE_W | Read data from the bus, by lane |
| bus_done | input | 1 | Current bus cycle completes at this edge |

## Verification
The assertions assume that bus_done is raised only while bus_req is 1 and lasts a single clock for each cycle. They also assume the bus never ends a cycle before the sequencer has presented it. The bench's bus model follows both rules: it raises bus_done for one clock after a programmable wait, then drops it before it looks at the next cycle. It returns a marker byte on any lane that is not enabled, so if the block picks the wrong lane the read value is wrong. Request fields are captured at acceptance, so the stimulus changes them freely afterwards. Addresses at the top of the byte space wrap, and the reference model wraps in the same way.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CYCLE1 = 2'd1,
    ST_CYCLE2 = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    CK_NONE = 2'd0,
    CK_WORD = 2'd1,
    CK_HIGH = 2'd2,
    CK_LOW  = 2'd3
  } cyc_kind_e;

endpackage

// File: rtl/wsplit_ctrl.sv
module wsplit_ctrl
  import wsplit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       split,
  input  logic       bus_done,
  output seq_state_e state,
  output logic       accept
);

  seq_state_e state_q;
  seq_state_e state_d;

  assign accept = req_valid && (state_q == ST_IDLE);
  assign state  = state_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = ST_CYCLE1;
      ST_CYCLE1: if (bus_done) state_d = split ? ST_CYCLE2 : ST_DONE;
      ST_CYCLE2: if (bus_done) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R7: an accepted request always starts a bus cycle next
  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state_q == ST_CYCLE1));

  // R8: the done state never lasts more than one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/wsplit_lane.sv
module wsplit_lane
  import wsplit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  seq_state_e              state,
  input  logic                    byte_only,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [2*BYTE_W-1:0]     wdata,
  output cyc_kind_e               kind,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic                    hi_en,
  output logic                    lo_en,
  output logic [2*BYTE_W-1:0]     bus_wdata
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [BYTE_W-1:0] BYTE_ZERO = '0;

  logic [BYTE_W-1:0] byte_lo;
  logic [BYTE_W-1:0] byte_hi;
  logic              second;

  assign byte_lo = wdata[BYTE_W-1:0];
  assign byte_hi = wdata[WORD_W-1:BYTE_W];
  assign second  = (state == ST_CYCLE2);

  always_comb begin
    kind     = CK_NONE;
    bus_addr = addr;
    case (state)
      ST_CYCLE1: begin
        if (addr[0]) kind = CK_HIGH;
        else         kind = byte_only ? CK_LOW : CK_WORD;
      end
      ST_CYCLE2: begin
        kind     = CK_LOW;
        bus_addr = addr + ADDR_ONE;
      end
      default: kind = CK_NONE;
    endcase
  end

  assign hi_en = (kind == CK_WORD) || (kind == CK_HIGH);
  assign lo_en = (kind == CK_WORD) || (kind == CK_LOW);

  always_comb begin
    case (kind)
      CK_WORD: bus_wdata = wdata;
      CK_HIGH: bus_wdata = {byte_lo, BYTE_ZERO};
      CK_LOW:  bus_wdata = {BYTE_ZERO, second ? byte_hi : byte_lo};
      default: bus_wdata = '0;
    endcase
  end

endmodule

// File: rtl/wsplit_gather.sv
module wsplit_gather
  import wsplit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                load,
  input  logic                second,
  input  cyc_kind_e           kind,
  input  logic [2*BYTE_W-1:0] bus_rdata,
  output logic [2*BYTE_W-1:0] acc
);

  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (clear) begin
      acc_d = '0;
    end else if (load) begin
      case (kind)
        CK_WORD: acc_d = bus_rdata;
        CK_HIGH: acc_d[BYTE_W-1:0] = bus_rdata[WORD_W-1:BYTE_W];
        CK_LOW: begin
          if (second) acc_d[WORD_W-1:BYTE_W] = bus_rdata[BYTE_W-1:0];
          else        acc_d[BYTE_W-1:0]      = bus_rdata[BYTE_W-1:0];
        end
        default: acc_d = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              acc_q <= '0;
    else if (clear || load)  acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R5: the completing second cycle of a split is always a low-lane cycle
  p_second_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && second) |-> (kind == CK_LOW));

endmodule

// File: rtl/oddword_bus_seq.sv
module oddword_bus_seq
  import wsplit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_byte,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2*BYTE_W-1:0]   req_wdata,
  output logic                  rsp_valid,
  output logic [2*BYTE_W-1:0]   rsp_rdata,
  output logic                  bus_req,
  output logic                  bus_we,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic                  bus_hi_en,
  output logic                  bus_lo_en,
  output logic [2*BYTE_W-1:0]   bus_wdata,
  input  logic [2*BYTE_W-1:0]   bus_rdata,
  input  logic                  bus_done
);

  localparam int WORD_W = 2 * BYTE_W;

  seq_state_e        state;
  cyc_kind_e         kind;
  logic              accept;
  logic              cap_write;
  logic              cap_byte;
  logic [ADDR_W-1:0] cap_addr;
  logic [WORD_W-1:0] cap_wdata;
  logic              split;
  logic              in_cycle;
  logic              rd_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_write <= 1'b0;
      cap_byte  <= 1'b0;
      cap_addr  <= '0;
      cap_wdata <= '0;
    end else if (accept) begin
      cap_write <= req_write;
      cap_byte  <= req_byte;
      cap_addr  <= req_addr;
      cap_wdata <= req_wdata;
    end
  end

  assign split    = !cap_byte && cap_addr[0];
  assign in_cycle = (state == ST_CYCLE1) || (state == ST_CYCLE2);
  assign rd_load  = in_cycle && bus_done && !cap_write;

  wsplit_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .split     (split),
    .bus_done  (bus_done),
    .state     (state),
    .accept    (accept)
  );

  wsplit_lane #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_lane (
    .state     (state),
    .byte_only (cap_byte),
    .addr      (cap_addr),
    .wdata     (cap_wdata),
    .kind      (kind),
    .bus_addr  (bus_addr),
    .hi_en     (bus_hi_en),
    .lo_en     (bus_lo_en),
    .bus_wdata (bus_wdata)
  );

  wsplit_gather #(.BYTE_W(BYTE_W)) u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .load      (rd_load),
    .second    (state == ST_CYCLE2),
    .kind      (kind),
    .bus_rdata (bus_rdata),
    .acc       (rsp_rdata)
  );

  assign req_ready = (state == ST_IDLE);
  assign bus_req   = in_cycle;
  assign bus_we    = in_cycle && cap_write;
  assign rsp_valid = (state == ST_DONE);

  // R1: no lane is enabled outside a bus cycle
  p_quiet_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (!bus_hi_en && !bus_lo_en));

  // R3: an odd bus address never carries the low lane
  p_odd_no_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr[0]) |-> !bus_lo_en);

  // R9: the cycle holds steady through wait states
  p_hold_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_hi_en)
                                && $stable(bus_lo_en) && $stable(bus_wdata)));

  // R8: the response is a single-cycle pulse followed by readiness
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R7: no new request is accepted while cycles are in flight
  p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !req_ready);

endmodule

// File: tb/tb_oddword_bus_seq.sv
`timescale 1ns/1ps
module tb_oddword_bus_seq;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_byte;
  logic        req_ready;
  logic [15:0] req_addr, req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        bus_req, bus_we, bus_hi_en, bus_lo_en, bus_done;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  oddword_bus_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_hi_en(bus_hi_en), .bus_lo_en(bus_lo_en), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_done(bus_done)
  );

  // Bus model: byte memory, lanes map to even/odd bytes
  logic [7:0]  bmem [256];
  int          wait_cfg = 0;
  int          cnt;
  int          tot_cyc = 0;
  int          stab_err = 0;
  logic [15:0] st_addr, st_wd;
  logic [15:0] log_addr [4];
  logic [15:0] log_wd   [4];
  logic [1:0]  log_ln   [4];
  logic        log_we   [4];

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= 0;
      bus_done  <= 1'b0;
      bus_rdata <= 16'h0;
      for (int i = 0; i < 256; i++) bmem[i] <= 8'(i * 7 + 3);
    end else if (bus_done) begin
      bus_done <= 1'b0;
      cnt      <= 0;
    end else if (bus_req) begin
      if (cnt == 0) begin
        st_addr <= bus_addr;
        st_wd   <= bus_wdata;
      end else if (st_addr != bus_addr || st_wd != bus_wdata) begin
        stab_err <= stab_err + 1;
      end
      if (cnt == wait_cfg) begin
        bus_done <= 1'b1;
        bus_rdata <= {bus_hi_en ? bmem[{bus_addr[7:1], 1'b1}] : 8'hEE,
                      bus_lo_en ? bmem[{bus_addr[7:1], 1'b0}] : 8'hEE};
        if (bus_we && bus_lo_en) bmem[{bus_addr[7:1], 1'b0}] <= bus_wdata[7:0];
        if (bus_we && bus_hi_en) bmem[{bus_addr[7:1], 1'b1}] <= bus_wdata[15:8];
        log_addr[tot_cyc[1:0]] <= bus_addr;
        log_wd[tot_cyc[1:0]]   <= bus_wdata;
        log_ln[tot_cyc[1:0]]   <= {bus_hi_en, bus_lo_en};
        log_we[tot_cyc[1:0]]   <= bus_we;
        tot_cyc <= tot_cyc + 1;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  logic [7:0] rmem [256];

  task automatic init_ref();
    for (int i = 0; i < 256; i++) rmem[i] = 8'(i * 7 + 3);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic w, input logic b, input logic [15:0] a,
                        input logic [15:0] wd, output logic [15:0] rd,
                        output int ncyc, output int base);
    bit busy_bad = 0;
    bit got = 0;
    @(negedge clk);
    base = tot_cyc;
    req_valid = 1'b1; req_write = w; req_byte = b; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = ~w; req_addr = 16'hDEAD; req_wdata = 16'hBEEF;
    for (int k = 0; k < 200; k++) begin
      if (rsp_valid) begin got = 1; break; end
      if (req_ready) busy_bad = 1;
      @(negedge clk);
    end
    chk(got, "R8 response arrives", 32'(got), 1);
    chk(!busy_bad && !req_ready, "R7 ready low while busy", 32'(busy_bad), 0);
    rd   = rsp_rdata;
    ncyc = tot_cyc - base;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R8 single pulse then ready",
        {30'd0, req_ready, rsp_valid}, 32'h2);
  endtask

  // {write, byte, addr, wdata, cycles, first lanes {hi,lo}}
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'h0010, 16'hA1B2, 2'd1, 2'b11},
    {1'b0, 1'b0, 16'h0010, 16'h0000, 2'd1, 2'b11},
    {1'b1, 1'b0, 16'h0021, 16'hC3D4, 2'd2, 2'b10},
    {1'b0, 1'b0, 16'h0021, 16'h0000, 2'd2, 2'b10},
    {1'b0, 1'b0, 16'h0020, 16'h0000, 2'd1, 2'b11},
    {1'b0, 1'b0, 16'h0022, 16'h0000, 2'd1, 2'b11},
    {1'b1, 1'b1, 16'h0030, 16'h995A, 2'd1, 2'b01},
    {1'b1, 1'b1, 16'h0031, 16'h886B, 2'd1, 2'b10},
    {1'b0, 1'b0, 16'h0030, 16'h0000, 2'd1, 2'b11},
    {1'b0, 1'b1, 16'h0031, 16'h0000, 2'd1, 2'b10},
    {1'b0, 1'b1, 16'h0030, 16'h0000, 2'd1, 2'b01},
    {1'b0, 1'b0, 16'h0045, 16'h0000, 2'd2, 2'b10},
    {1'b1, 1'b0, 16'h00FF, 16'h1234, 2'd2, 2'b10},
    {1'b0, 1'b0, 16'h00FF, 16'h0000, 2'd2, 2'b10}
  };

  task automatic run_one(input logic w, input logic b, input logic [15:0] a,
                         input logic [15:0] wd, input int ec, input logic [1:0] el);
    logic [15:0] rd, exp_rd;
    int ncyc, base;
    logic [7:0] a0, a1;
    string ct;
    a0 = a[7:0];
    a1 = a0 + 8'd1;
    ct = b ? "R6" : (a[0] ? "R3" : "R2");
    exp_rd = b ? {8'h00, rmem[a0]} : {rmem[a1], rmem[a0]};
    do_req(w, b, a, wd, rd, ncyc, base);
    if (w) begin
      rmem[a0] = wd[7:0];
      if (!b) rmem[a1] = wd[15:8];
    end
    chk(ncyc == ec, {ct, " cycle count"}, 32'(ncyc), 32'(ec));
    chk(log_addr[base[1:0]] == a, {ct, " first address"}, 32'(log_addr[base[1:0]]), 32'(a));
    chk(log_ln[base[1:0]] == el, {ct, " first lanes"}, 32'(log_ln[base[1:0]]), 32'(el));
    chk(log_we[base[1:0]] == w, "R10 bus_we cycle1", 32'(log_we[base[1:0]]), 32'(w));
    if (ec == 2) begin
      chk(log_addr[(base + 1) % 4] == a + 16'd1, "R3 second address",
          32'(log_addr[(base + 1) % 4]), 32'(a + 16'd1));
      chk(log_ln[(base + 1) % 4] == 2'b01, "R3 second lanes",
          32'(log_ln[(base + 1) % 4]), 1);
      chk(log_we[(base + 1) % 4] == w, "R10 bus_we cycle2",
          32'(log_we[(base + 1) % 4]), 32'(w));
    end
    if (w) begin
      chk(rd == 16'h0, "R8 write response data zero", 32'(rd), 0);
      if (ec == 2) begin
        chk(log_wd[base[1:0]][15:8] == wd[7:0], "R4 first cycle high lane",
            32'(log_wd[base[1:0]][15:8]), 32'(wd[7:0]));
        chk(log_wd[(base + 1) % 4][7:0] == wd[15:8], "R4 second cycle low lane",
            32'(log_wd[(base + 1) % 4][7:0]), 32'(wd[15:8]));
      end else if (b) begin
        chk((a[0] ? log_wd[base[1:0]][15:8] : log_wd[base[1:0]][7:0]) == wd[7:0],
            "R6 byte write lane data", 32'(log_wd[base[1:0]]), 32'(wd[7:0]));
      end else begin
        chk(log_wd[base[1:0]] == wd, "R2 word write data", 32'(log_wd[base[1:0]]), 32'(wd));
      end
    end else begin
      chk(rd == exp_rd, b ? "R6 byte read data" : (a[0] ? "R5 split read data" : "R2 word read data"),
          32'(rd), 32'(exp_rd));
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int ncyc, base;
    req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0;
    req_addr = 16'h0; req_wdata = 16'h0;
    init_ref();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_req && !bus_hi_en && !bus_lo_en && !rsp_valid,
        "R1 state during reset",
        {27'd0, req_ready, bus_req, bus_hi_en, bus_lo_en, rsp_valid}, 32'h10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_req && !rsp_valid, "R1 state after reset",
        {29'd0, req_ready, bus_req, rsp_valid}, 32'h4);

    for (int i = 0; i < NV; i++) begin
      run_one(VEC[i][37], VEC[i][36], VEC[i][35:20], VEC[i][19:4],
              int'(VEC[i][3:2]), VEC[i][1:0]);
    end

    // R9: wait states on split write and read
    wait_cfg = 3;
    run_one(1'b1, 1'b0, 16'h0053, 16'h7E81, 2, 2'b10);
    run_one(1'b0, 1'b0, 16'h0053, 16'h0000, 2, 2'b10);
    run_one(1'b0, 1'b0, 16'h0054, 16'h0000, 1, 2'b11);
    chk(stab_err == 0, "R9 outputs stable during wait", 32'(stab_err), 0);

    // Back-to-back request right after a response
    wait_cfg = 0;
    run_one(1'b0, 1'b1, 16'h0053, 16'h0000, 1, 2'b10);
    run_one(1'b0, 1'b0, 16'h0052, 16'h0000, 1, 2'b11);

    // R1: reset in the middle of a cycle
    wait_cfg = 6;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_byte = 1'b0; req_addr = 16'h0061;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(bus_req, "R1 cycle running before reset", 32'(bus_req), 1);
    rst_n = 1'b0;
    #1;
    chk(req_ready && !bus_req && !bus_hi_en && !bus_lo_en && !rsp_valid,
        "R1 reset aborts cycle",
        {27'd0, req_ready, bus_req, bus_hi_en, bus_lo_en, rsp_valid}, 32'h10);
    @(negedge clk);
    rst_n = 1'b1;
    init_ref();
    wait_cfg = 0;
    run_one(1'b0, 1'b0, 16'h0061, 16'h0000, 2, 2'b10);
    do_req(1'b0, 1'b0, 16'h0062, 16'h0, rd, ncyc, base);
    chk(rd == {rmem[8'h63], rmem[8'h62]}, "R2 read after reset",
        32'(rd), 32'({rmem[8'h63], rmem[8'h62]}));

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule